// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is a combinational integer execution unit paired with a registered four-bit status register. Each cycle it takes an operation code, an operand size of 8, 16 or 32 bits, and two operands. It produces a result and a write-enable straight away, in the same cycle. The status flags are captured at the next rising clock edge.

The unit covers the following operations:

- two's-complement arithmetic: add, subtract, increment, decrement and negate;
- bitwise logic: and, or, xor and not;
- three shifts: left, logical right and arithmetic right;
- flag-only comparisons: compare and test;
- width-extending copies, signed or unsigned.

All flags are computed at the selected width. Result bits above that width are always zero. A surrounding datapath writes the result to its register file only when the write-enable is high. Branch or set-on-condition logic reads the flags.

Top module: `int_alu_flags`

## Requirements
- R1: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. The arithmetic codes are add 0, sub 1, inc 2, dec 3 and neg 4. Their results are, in two's complement at the selected width: a+b, a-b, a+1, a-1 and 0-a. Bits of the result above the width are zero.
- R2: The flag output holds carry in bit 0, zero in bit 1, sign in bit 2 and overflow in bit 3. It clears to 0 during reset. A flag change appears after the rising clock edge that samples the operation.
- R3: Carry is the carry out of the top bit of the width for add and inc. For sub, compare and neg, carry is a borrow: it is set when the first operand (0 for neg) is below the second operand as unsigned numbers.
- R4: Zero is set when the width-masked result equals 0. Sign is the top bit of the width-masked result.
- R5: Overflow for the arithmetic operations and compare is set on two's-complement overflow at the selected width.
- R6: Compare (code 12) sets the flags as for a-b. Test (code 13) sets them as for a&b. Neither raises the write-enable.
- R7: The codes and 5, or 6 and xor 7 write a&b, a|b and a^b. Test behaves like these for flags. All of them clear carry and overflow. Not (code 8) writes ~a and leaves every flag unchanged.
- R8: Inc and dec update zero, sign and overflow but leave carry unchanged.
- R9: Shift left (code 9), arithmetic right (code 10) and logical right (code 11) shift a by b[4:0]. Arithmetic right fills with the sign bit of the width; the other two shifts fill with zeros. Carry is the last bit shifted out. When the count exceeds the width, carry is 0 for the zero-filling shifts and the sign bit for arithmetic right.
- R10: A shift whose masked count is 0 writes a unchanged and leaves all flags unchanged.
- R11: Sign-extend (code 14) and zero-extend (code 15) copy the low byte of a when b[0] is 0, and the low word when b[0] is 1. The copy is extended to the selected width. Both leave the flags unchanged.
- R12: The write-enable is high exactly when en_i is high and the operation is neither compare nor test. When en_i is low, the flags hold.
- R13: Shift overflow is the result's top bit xor carry for a left shift, the operand's top bit for a logical right shift, and 0 for an arithmetic right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset of the flag register |
| en_i | input | 1 | Operation issue strobe |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand width code |
| a_i | input | 32 | Destination / first operand |
| b_i | input | 32 | Source / second operand, shift count, extension source select |
| res_o | output | 32 | Width-masked result |
| wr_en_o | output | 1 | Result write-enable |
| flags_o | output | 4 | Registered flags {overflow, sign, zero, carry} |

## Verification
The assertions check several rules on every cycle:

- compare and test never write;
- idle cycles, not, extensions and zero-count shifts preserve the flags;
- logical operations clear carry and overflow;
- inc and dec carry the old carry forward;
- the zero flag agrees with the previous result;
- byte results keep their upper bits clear.

The exact result values, borrow and overflow at each width, shift fills, over-width shift counts and extension patterns can only be shown by the bench's vectors and directed sequences. So can the way inc and dec carry a previously set carry forward.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned CW = $clog2(DW);

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_INC  = 4'd2,
        OP_DEC  = 4'd3,
        OP_NEG  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_NOT  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SAR  = 4'd10,
        OP_SHR  = 4'd11,
        OP_CMP  = 4'd12,
        OP_TST  = 4'd13,
        OP_SEXT = 4'd14,
        OP_ZEXT = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic cry;
    } flags_t;

    function automatic logic [DW-1:0] width_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return {{(DW-8){1'b0}}, 8'hFF};
            2'd1:    return {{(DW-16){1'b0}}, 16'hFFFF};
            default: return '1;
        endcase
    endfunction

    function automatic int unsigned top_bit(input logic [1:0] sz);
        case (sz)
            2'd0:    return 7;
            2'd1:    return 15;
            default: return DW - 1;
        endcase
    endfunction

    function automatic logic [DW-1:0] sext_from(input logic [DW-1:0] v, input logic [1:0] sz);
        case (sz)
            2'd0:    return {{(DW-8){v[7]}}, v[7:0]};
            2'd1:    return {{(DW-16){v[15]}}, v[15:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
(
    input  alu_op_e          op_i,
    input  logic [1:0]       size_i,
    input  logic [DW-1:0]    a_i,
    input  logic [DW-1:0]    b_i,
    output logic [DW-1:0]    res_o,
    output logic             cry_o,
    output logic             ovf_o
);

    logic [DW-1:0] x, y;
    logic          sub;
    logic [DW:0]   wide;
    int unsigned   hb;

    always_comb begin
        x   = a_i;
        y   = b_i;
        sub = 1'b0;
        case (op_i)
            OP_SUB, OP_CMP: sub = 1'b1;
            OP_INC:         y = DW'(1);
            OP_DEC: begin
                y   = DW'(1);
                sub = 1'b1;
            end
            OP_NEG: begin
                x   = '0;
                y   = a_i;
                sub = 1'b1;
            end
            default: ;
        endcase
        hb    = top_bit(size_i);
        wide  = sub ? ({1'b0, x} - {1'b0, y}) : ({1'b0, x} + {1'b0, y});
        res_o = wide[DW-1:0] & width_mask(size_i);
        cry_o = sub ? (x < y) : wide[hb+1];
        if (sub) begin
            ovf_o = (x[hb] != y[hb]) && (res_o[hb] != x[hb]);
        end else begin
            ovf_o = (x[hb] == y[hb]) && (res_o[hb] != x[hb]);
        end
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
(
    input  alu_op_e          op_i,
    input  logic [1:0]       size_i,
    input  logic [DW-1:0]    a_i,
    input  logic [CW-1:0]    cnt_i,
    output logic [DW-1:0]    res_o,
    output logic             cry_o,
    output logic             ovf_o
);

    logic [DW-1:0]   src;
    logic            fill;
    logic [2*DW:0]   rt;
    logic [2*DW-1:0] lt;
    int unsigned     hb;

    always_comb begin
        hb   = top_bit(size_i);
        src  = (op_i == OP_SAR) ? sext_from(a_i, size_i) : a_i;
        fill = (op_i == OP_SAR) ? src[DW-1] : 1'b0;
        rt   = {{DW{fill}}, src, 1'b0} >> cnt_i;
        lt   = {{DW{1'b0}}, a_i} << cnt_i;
        if (op_i == OP_SHL) begin
            res_o = lt[DW-1:0] & width_mask(size_i);
            cry_o = lt[hb+1];
            ovf_o = res_o[hb] ^ cry_o;
        end else begin
            res_o = rt[DW:1] & width_mask(size_i);
            cry_o = rt[0];
            ovf_o = (op_i == OP_SHR) ? a_i[hb] : 1'b0;
        end
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
(
    input  alu_op_e          op_i,
    input  logic [1:0]       size_i,
    input  logic [DW-1:0]    a_i,
    input  logic [DW-1:0]    b_i,
    output logic [DW-1:0]    res_o
);

    logic [DW-1:0] raw;

    always_comb begin
        case (op_i)
            OP_AND, OP_TST: raw = a_i & b_i;
            OP_OR:          raw = a_i | b_i;
            OP_XOR:         raw = a_i ^ b_i;
            OP_NOT:         raw = ~a_i;
            OP_SEXT:        raw = b_i[0] ? sext_from(a_i, 2'd1) : sext_from(a_i, 2'd0);
            OP_ZEXT:        raw = b_i[0] ? {{(DW-16){1'b0}}, a_i[15:0]}
                                         : {{(DW-8){1'b0}}, a_i[7:0]};
            default:        raw = '0;
        endcase
        res_o = raw & width_mask(size_i);
    end

endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
    import alu_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic [3:0]    op_i,
    input  logic [1:0]    size_i,
    input  logic [31:0]   a_i,
    input  logic [31:0]   b_i,
    output logic [31:0]   res_o,
    output logic          wr_en_o,
    output logic [3:0]    flags_o
);

    typedef struct packed {
        flags_t flags;
    } state_t;

    state_t        st_d, st_q;
    alu_op_e       op;
    logic [DW-1:0] mask, am, bm;
    logic [DW-1:0] ar_res, sh_res, lg_res;
    logic          ar_c, ar_o, sh_c, sh_o;
    logic          zf, sf, cnt_zero;

    assign op       = alu_op_e'(op_i);
    assign mask     = width_mask(size_i);
    assign am       = a_i & mask;
    assign bm       = b_i & mask;
    assign cnt_zero = (b_i[CW-1:0] == '0);

    alu_arith u_arith (
        .op_i   (op),
        .size_i (size_i),
        .a_i    (am),
        .b_i    (bm),
        .res_o  (ar_res),
        .cry_o  (ar_c),
        .ovf_o  (ar_o)
    );

    alu_shift u_shift (
        .op_i   (op),
        .size_i (size_i),
        .a_i    (am),
        .cnt_i  (b_i[CW-1:0]),
        .res_o  (sh_res),
        .cry_o  (sh_c),
        .ovf_o  (sh_o)
    );

    alu_logic u_logic (
        .op_i   (op),
        .size_i (size_i),
        .a_i    (am),
        .b_i    (b_i),
        .res_o  (lg_res)
    );

    always_comb begin
        case (op)
            OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_NEG, OP_CMP: res_o = ar_res;
            OP_SHL, OP_SAR, OP_SHR:                         res_o = sh_res;
            default:                                        res_o = lg_res;
        endcase
        zf      = (res_o == '0);
        sf      = res_o[top_bit(size_i)];
        wr_en_o = en_i && (op != OP_CMP) && (op != OP_TST);

        st_d = st_q;
        if (en_i) begin
            case (op)
                OP_ADD, OP_SUB, OP_NEG, OP_CMP:
                    st_d.flags = '{ovf: ar_o, sgn: sf, zro: zf, cry: ar_c};
                OP_INC, OP_DEC:
                    st_d.flags = '{ovf: ar_o, sgn: sf, zro: zf, cry: st_q.flags.cry};
                OP_AND, OP_OR, OP_XOR, OP_TST:
                    st_d.flags = '{ovf: 1'b0, sgn: sf, zro: zf, cry: 1'b0};
                OP_SHL, OP_SAR, OP_SHR:
                    if (!cnt_zero) begin
                        st_d.flags = '{ovf: sh_o, sgn: sf, zro: zf, cry: sh_c};
                    end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
    import alu_pkg::*;
(
    input logic        clk_i,
    input logic        rst_ni,
    input logic        en_i,
    input logic [3:0]  op_i,
    input logic [1:0]  size_i,
    input logic [31:0] a_i,
    input logic [31:0] b_i,
    input logic [31:0] res_o,
    input logic        wr_en_o,
    input logic [3:0]  flags_o
);

    logic is_logic, is_shift, is_zset;

    assign is_logic = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR) || (op_i == OP_TST);
    assign is_shift = (op_i == OP_SHL) || (op_i == OP_SAR) || (op_i == OP_SHR);
    assign is_zset  = is_logic || (op_i == OP_ADD) || (op_i == OP_SUB) || (op_i == OP_CMP)
                      || (op_i == OP_NEG);

    AST_CMP_TST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((op_i == OP_CMP) || (op_i == OP_TST)) |-> !wr_en_o); // R6

    AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> !wr_en_o); // R12

    AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(flags_o)); // R12

    AST_LOGIC_CLEARS_CO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && is_logic) |=> (flags_o[0] == 1'b0) && (flags_o[3] == 1'b0)); // R7

    AST_NOT_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && (op_i == OP_NOT)) |=> $stable(flags_o)); // R7

    AST_INCDEC_KEEPS_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && ((op_i == OP_INC) || (op_i == OP_DEC))) |=> $stable(flags_o[0])); // R8

    AST_ZERO_COUNT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && is_shift && (b_i[4:0] == 5'd0)) |=> $stable(flags_o)); // R10

    AST_EXT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && ((op_i == OP_SEXT) || (op_i == OP_ZEXT))) |=> $stable(flags_o)); // R11

    AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && is_zset) |=> (flags_o[1] == ($past(res_o) == 32'd0))); // R4

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (size_i == 2'd0) |-> (res_o[31:8] == 24'd0)); // R1

endmodule

bind int_alu_flags alu_flags_chk u_alu_flags_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .op_i    (op_i),
    .size_i  (size_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .res_o   (res_o),
    .wr_en_o (wr_en_o),
    .flags_o (flags_o)
);

// File: tb/test_int_alu_flags.sv
`timescale 1ns/1ps
module test_int_alu_flags;

    localparam logic [3:0] ADD = 4'd0, SUB = 4'd1, INC = 4'd2, DEC = 4'd3, NEG = 4'd4;
    localparam logic [3:0] AND_ = 4'd5, OR_ = 4'd6, XOR_ = 4'd7, NOT_ = 4'd8;
    localparam logic [3:0] SHL = 4'd9, SAR = 4'd10, SHR = 4'd11, CMP = 4'd12, TST = 4'd13;
    localparam logic [3:0] SEXT = 4'd14, ZEXT = 4'd15;

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  sz;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        wr;
        logic [3:0]  fl;
    } vec_t;

    // flags written as {overflow, sign, zero, carry}
    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{ADD,  2'd0, 32'h0000_007F, 32'h0000_0001, 32'h0000_0080, 1'b1, 4'hC}, // R5 signed overflow
        '{ADD,  2'd0, 32'h0000_00FF, 32'h0000_0001, 32'h0000_0000, 1'b1, 4'h3}, // R3 carry out, R4
        '{ADD,  2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 4'h3}, // R3 at 32 bits
        '{ADD,  2'd1, 32'hABCD_1234, 32'h0001_0001, 32'h0000_1235, 1'b1, 4'h0}, // R1 masking
        '{SUB,  2'd1, 32'h0000_0000, 32'h0000_0001, 32'h0000_FFFF, 1'b1, 4'h5}, // R3 borrow
        '{SUB,  2'd2, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1, 4'h8}, // R5
        '{CMP,  2'd0, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b0, 4'h2}, // R6 equal
        '{CMP,  2'd0, 32'h0000_0003, 32'h0000_0007, 32'h0000_0000, 1'b0, 4'h5}, // R6 below
        '{NEG,  2'd0, 32'h0000_0080, 32'h0000_0000, 32'h0000_0080, 1'b1, 4'hD}, // R1 neg of min
        '{AND_, 2'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h0000_0000, 1'b1, 4'h2}, // R7 clears C,O
        '{NEG,  2'd2, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, 4'h2}, // R3 neg of zero
        '{XOR_, 2'd1, 32'h0000_8000, 32'h0000_0001, 32'h0000_8001, 1'b1, 4'h4}, // R7
        '{OR_,  2'd0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, 4'h2}, // R7
        '{TST,  2'd0, 32'h0000_0080, 32'h0000_00FF, 32'h0000_0000, 1'b0, 4'h4}, // R6 test
        '{SHL,  2'd0, 32'h0000_0081, 32'h0000_0001, 32'h0000_0002, 1'b1, 4'h9}, // R9 R13
        '{SHR,  2'd0, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 1'b1, 4'h3}, // R9
        '{SAR,  2'd0, 32'h0000_0080, 32'h0000_0003, 32'h0000_00F0, 1'b1, 4'h4}, // R9 sign fill
        '{SAR,  2'd1, 32'h0000_8000, 32'h0000_0014, 32'h0000_FFFF, 1'b1, 4'h5}, // R9 over width
        '{SHL,  2'd2, 32'h4000_0000, 32'h0000_0021, 32'h8000_0000, 1'b1, 4'hC}, // R9 mask, R13
        '{SHR,  2'd2, 32'h8000_0000, 32'h0000_001F, 32'h0000_0001, 1'b1, 4'h8}, // R13
        '{XOR_, 2'd2, 32'h5A5A_5A5A, 32'h5A5A_5A5A, 32'h0000_0000, 1'b1, 4'h2}, // R4
        '{SUB,  2'd0, 32'h0000_0080, 32'h0000_0001, 32'h0000_007F, 1'b1, 4'h8}, // R5
        '{ADD,  2'd1, 32'h0000_8000, 32'h0000_8000, 32'h0000_0000, 1'b1, 4'hB}  // R3 R5
    };

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        en_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [31:0] res_o;
    logic        wr_en_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int errors = 0;

    always #2 clk_i = ~clk_i;

    int_alu_flags i_int_alu_flags (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .op_i    (op_i),
        .size_i  (size_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .res_o   (res_o),
        .wr_en_o (wr_en_o),
        .flags_o (flags_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run(input string tag, input logic [3:0] op, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] b, input logic en,
                       input logic exp_wr, input logic [31:0] exp_res, input logic [3:0] exp_fl);
        @(negedge clk_i);
        op_i = op; size_i = sz; a_i = a; b_i = b; en_i = en;
        #1;
        chk({tag, " wr_en"}, 32'(wr_en_o), 32'(exp_wr));
        if (exp_wr) chk({tag, " result"}, res_o, exp_res);
        @(posedge clk_i);
        #1;
        chk({tag, " flags"}, 32'(flags_o), 32'(exp_fl));
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk_i);
        #1;
        chk("R2 reset flags", 32'(flags_o), 32'h0);
        chk("R12 reset wr_en", 32'(wr_en_o), 32'h0);
        @(negedge clk_i);
        rst_ni = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run($sformatf("R1/R3/R4/R5 vector %0d", i), VEC[i].op, VEC[i].sz, VEC[i].a,
                VEC[i].b, 1'b1, VEC[i].wr, VEC[i].res, VEC[i].fl);
        end

        // carry is 1 after the last vector
        run("R8 inc keeps set carry",  INC, 2'd0, 32'h7F, 32'h0, 1'b1, 1'b1, 32'h80, 4'hD);
        run("R8 dec keeps set carry",  DEC, 2'd0, 32'h00, 32'h0, 1'b1, 1'b1, 32'hFF, 4'h5);
        run("R2 add clears carry",     ADD, 2'd0, 32'h01, 32'h1, 1'b1, 1'b1, 32'h02, 4'h0);
        run("R8 dec keeps clear carry", DEC, 2'd0, 32'h80, 32'h0, 1'b1, 1'b1, 32'h7F, 4'h8);
        run("R7 not keeps flags",      NOT_, 2'd0, 32'hFFFF_FF0F, 32'h0, 1'b1, 1'b1, 32'hF0, 4'h8);
        run("R10 zero count shift",    SHL, 2'd2, 32'h1234_5678, 32'h20, 1'b1, 1'b1, 32'h1234_5678, 4'h8);
        run("R10 zero count sar",      SAR, 2'd0, 32'h0000_0080, 32'h0, 1'b1, 1'b1, 32'h80, 4'h8);
        run("R12 idle holds",          ADD, 2'd0, 32'hFF, 32'h1, 1'b0, 1'b0, 32'h0, 4'h8);
        run("R11 sext byte->word",     SEXT, 2'd1, 32'h0000_0080, 32'h0, 1'b1, 1'b1, 32'h0000_FF80, 4'h8);
        run("R11 sext byte->dword pos", SEXT, 2'd2, 32'hAAAA_AA7F, 32'h0, 1'b1, 1'b1, 32'h0000_007F, 4'h8);
        run("R11 sext word->dword",    SEXT, 2'd2, 32'h0000_8001, 32'h1, 1'b1, 1'b1, 32'hFFFF_8001, 4'h8);
        run("R11 zext byte->dword",    ZEXT, 2'd2, 32'hFFFF_FF90, 32'h0, 1'b1, 1'b1, 32'h0000_0090, 4'h8);
        run("R11 zext word->dword",    ZEXT, 2'd2, 32'h1234_ABCD, 32'h1, 1'b1, 1'b1, 32'h0000_ABCD, 4'h8);
        run("R6 cmp after ext",        CMP, 2'd2, 32'h1, 32'h2, 1'b1, 1'b0, 32'h0, 4'h5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule